// File: doc/BRIEF.md
# Delayed UART Interrupt Controller

This block produces the single console interrupt line of a UART register interface and the code a driver reads to find out why it was interrupted. It tracks two pending sources, received data (RX) and transmitter empty (TX). Each source owns a retriggerable delay timer. A request starts that timer, and the timer expires a fixed number of clock cycles later. The delay is deliberate: it slows down a driver that polls the device in a tight loop. Each new request restarts the countdown from the full interval.

The surrounding register decoder sends the block strobes: schedule requests for either source, writes of the interrupt enable value, reads of the identification value, and the arrival of fresh receive data. It also supplies a level that says whether receive data is waiting. When the TX enable is written, the block uses an age counter to decide whether to fire the TX interrupt on the same edge or to defer it. The identification output always reflects the current pending state, with RX taking priority.

Top module: `uart_irq_delay`

## Requirements
- R1: After reset, `irq` is 0, `id_code` is 0x01, both delay timers are stopped, and the TX age counter is saturated. As a result, the first TX enable write fires at once.
- R2: A schedule request sampled at clock edge E sets that source's pending bit at edge E+DELAY_CYC, provided that source's enable is set. `irq` is 1 from then on.
- R3: A second request for the same source, made while its timer is running, restarts the countdown. The pending bit is then set DELAY_CYC edges after the latest request. The earlier request never causes a set.
- R4: When a timer expires while its source's enable bit is 0, the pending bit stays clear and `irq` is unchanged.
- R5: If no TX interrupt has been raised for more than DELAY_CYC cycles, an enable write with bit 1 (TX enable) = 1 sets TX pending on the same edge.
- R6: If a TX interrupt was raised within the last DELAY_CYC cycles, an enable write with bit 1 = 1 does not set TX pending at once. Instead it starts the TX timer, and TX pending is set DELAY_CYC edges later.
- R7: An enable write with bit 1 = 0 clears TX pending on that edge and stops the TX timer, so the stopped timer never sets TX pending.
- R8: An enable write with bit 0 (RX enable) = 1 while `rx_avail` is 1 starts the RX timer. Any other enable write clears RX pending and stops the RX timer.
- R9: `id_code` is 0x04 when RX is pending, otherwise 0x02 when TX is pending, otherwise 0x01. `irq` is the OR of the two pending bits.
- R10: An identification read strobe clears TX pending when the code shown is 0x02. It leaves RX pending untouched.
- R11: An `rx_arrive` pulse with RX enable set raises RX pending and `irq` on the same edge, with no delay. With RX enable clear, it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_req | input | 1 | Restart RX delay; clears RX pending |
| tx_req | input | 1 | Restart TX delay; clears TX pending |
| en_wr | input | 1 | Enable-value write strobe |
| en_wdata | input | 2 | Enable value: bit 0 RX enable, bit 1 TX enable |
| id_rd | input | 1 | Identification read strobe |
| rx_avail | input | 1 | Receive data waiting (level) |
| rx_arrive | input | 1 | Fresh receive data pulse |
| irq | output | 1 | Console interrupt |
| id_code | output | 8 | Identification value |

## Verification
The block registers the pending bits once. Strobe-driven effects (enable writes, identification reads and data arrival) therefore show on the outputs one edge after the strobe is sampled. A timer-driven set shows exactly DELAY_CYC edges after the request edge. The bench drives inputs on falling edges and samples on falling edges. For every delayed case it checks both the edge before the due edge (expecting no interrupt) and the due edge itself, so a timer that is off by one cycle fails. Age-dependent TX cases stay well clear of the age boundary, so the outcome does not depend on rounding at the limit.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned EN_RX  = 0;
    localparam int unsigned EN_TX  = 1;
    localparam int unsigned SRC_RX = 0;
    localparam int unsigned SRC_TX = 1;
    localparam int unsigned NSRC   = 2;

    typedef enum logic [7:0] {
        ID_NONE = 8'h01,
        ID_TX   = 8'h02,
        ID_RX   = 8'h04
    } id_code_e;

    typedef struct packed {
        logic tx;
        logic rx;
    } pend_t;

    function automatic id_code_e id_pick(pend_t p);
        if (p.rx)
            return ID_RX;
        else if (p.tx)
            return ID_TX;
        else
            return ID_NONE;
    endfunction

endpackage

// File: rtl/uirq_delay_timer.sv
module uirq_delay_timer #(
    parameter int unsigned DELAY_CYC = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic fire
);
    localparam int unsigned CW = $clog2(DELAY_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    // start has priority over cancel; an expiry stops the timer
    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(DELAY_CYC);
        end else if (cancel) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == CW'(1))
                run_q <= 1'b0;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign fire = run_q && (cnt_q == CW'(1));

    assert_restart_full_R3: assert property (@(posedge clk) disable iff (rst)
        start |=> (run_q && cnt_q == CW'(DELAY_CYC)));

    assert_fire_once_R2: assert property (@(posedge clk) disable iff (rst)
        (fire && !start) |=> !run_q);

endmodule

// File: rtl/uirq_tx_age.sv
module uirq_tx_age #(
    parameter int unsigned DELAY_CYC = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic mark,
    output logic aged
);
    localparam int unsigned LIM = DELAY_CYC + 1;
    localparam int unsigned AW  = $clog2(LIM + 1);

    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= AW'(LIM);
        else if (mark)
            age_q <= '0;
        else if (age_q != AW'(LIM))
            age_q <= age_q + AW'(1);
    end

    assign aged = (age_q == AW'(LIM));

    assert_mark_resets_age_R6: assert property (@(posedge clk) disable iff (rst)
        mark |=> !aged);

endmodule

// File: rtl/uirq_id_encode.sv
module uirq_id_encode
    import uirq_pkg::*;
(
    input  pend_t       pend,
    output logic [7:0]  code
);
    id_code_e sel;

    always_comb begin
        sel  = id_pick(pend);
        code = sel;
    end

endmodule

// File: rtl/uart_irq_delay.sv
module uart_irq_delay
    import uirq_pkg::*;
#(
    parameter int unsigned DELAY_CYC = 23
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_req,
    input  logic       tx_req,
    input  logic       en_wr,
    input  logic [1:0] en_wdata,
    input  logic       id_rd,
    input  logic       rx_avail,
    input  logic       rx_arrive,
    output logic       irq,
    output logic [7:0] id_code
);
    logic [1:0]      en_q;
    logic [1:0]      en_next;
    pend_t           pend_q;
    pend_t           pend_d;
    logic [NSRC-1:0] t_start;
    logic [NSRC-1:0] t_cancel;
    logic [NSRC-1:0] t_fire;
    logic            tx_aged;
    logic            tx_now;
    logic            tx_set, tx_clr;
    logic            rx_set, rx_clr;
    logic            rx_keep;

    assign en_next = en_wr ? en_wdata : en_q;
    assign rx_keep = en_wdata[EN_RX] && rx_avail;
    assign tx_now  = en_wr && en_wdata[EN_TX] && tx_aged;

    always_comb begin
        t_start[SRC_RX]  = rx_req || (en_wr && rx_keep);
        t_cancel[SRC_RX] = en_wr && !rx_keep;
        t_start[SRC_TX]  = tx_req || (en_wr && en_wdata[EN_TX] && !tx_aged);
        t_cancel[SRC_TX] = en_wr && !en_wdata[EN_TX];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_timer
        uirq_delay_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .start  (t_start[g]),
            .cancel (t_cancel[g]),
            .fire   (t_fire[g])
        );
    end

    uirq_tx_age #(.DELAY_CYC(DELAY_CYC)) u_age (
        .clk  (clk),
        .rst  (rst),
        .mark (tx_set),
        .aged (tx_aged)
    );

    // sets win over clears; a set needs the enable in force after this edge
    always_comb begin
        tx_set = (t_fire[SRC_TX] || tx_now) && en_next[EN_TX];
        tx_clr = tx_req || (en_wr && !en_wdata[EN_TX])
              || (id_rd && !pend_q.rx && pend_q.tx);
        rx_set = (t_fire[SRC_RX] || rx_arrive) && en_next[EN_RX];
        rx_clr = rx_req || (en_wr && !rx_keep);

        pend_d = pend_q;
        if (tx_clr) pend_d.tx = 1'b0;
        if (rx_clr) pend_d.rx = 1'b0;
        if (tx_set) pend_d.tx = 1'b1;
        if (rx_set) pend_d.rx = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_next;
            pend_q <= pend_d;
        end
    end

    uirq_id_encode u_enc (
        .pend (pend_q),
        .code (id_code)
    );

    assign irq = pend_q.rx | pend_q.tx;

    assert_tx_off_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (en_wr && !en_wdata[EN_TX]) |=> !pend_q.tx);

    assert_tx_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.tx) |-> en_q[EN_TX]);

    assert_rx_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q.rx) |-> en_q[EN_RX]);

    assert_tx_immediate_R5: assert property (@(posedge clk) disable iff (rst)
        (en_wr && en_wdata[EN_TX] && tx_aged) |=> pend_q.tx);

    assert_id_read_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (id_rd && !pend_q.rx && pend_q.tx && !tx_set) |=> !pend_q.tx);

    assert_rx_arrive_R11: assert property (@(posedge clk) disable iff (rst)
        (rx_arrive && en_q[EN_RX] && !en_wr) |=> pend_q.rx);

    assert_id_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $countones(id_code) == 1);

endmodule

// File: tb/tb_uart_irq_delay.sv
module tb_uart_irq_delay;

    localparam int unsigned D      = 23;
    localparam time         CLK_PER = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_req = 1'b0, tx_req = 1'b0, en_wr = 1'b0, id_rd = 1'b0;
    logic       rx_avail = 1'b0, rx_arrive = 1'b0;
    logic [1:0] en_wdata = 2'b00;
    logic       irq;
    logic [7:0] id_code;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    uart_irq_delay #(.DELAY_CYC(D)) dut (
        .clk(clk), .rst(rst), .rx_req(rx_req), .tx_req(tx_req),
        .en_wr(en_wr), .en_wdata(en_wdata), .id_rd(id_rd),
        .rx_avail(rx_avail), .rx_arrive(rx_arrive),
        .irq(irq), .id_code(id_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic e_irq, input logic [7:0] e_id, input string tag);
        total++;
        if (irq !== e_irq || id_code !== e_id) begin
            bad++;
            $display("FAIL %s: irq=%0b id=0x%02h expected irq=%0b id=0x%02h",
                     tag, irq, id_code, e_irq, e_id);
        end
    endtask

    task automatic do_reset;
        rst = 1'b1; rx_req = 0; tx_req = 0; en_wr = 0; id_rd = 0;
        rx_avail = 0; rx_arrive = 0; en_wdata = 2'b00;
        step(3);
        rst = 1'b0;
    endtask

    task automatic write_en(input logic [1:0] v);
        en_wr = 1'b1; en_wdata = v; step(1); en_wr = 1'b0;
    endtask
    task automatic pulse_rx_req;  rx_req = 1'b1;    step(1); rx_req = 1'b0;    endtask
    task automatic pulse_tx_req;  tx_req = 1'b1;    step(1); tx_req = 1'b0;    endtask
    task automatic pulse_id_rd;   id_rd = 1'b1;     step(1); id_rd = 1'b0;     endtask
    task automatic pulse_arrive;  rx_arrive = 1'b1; step(1); rx_arrive = 1'b0; endtask

    task automatic t_reset_state;
        do_reset();
        expect_out(1'b0, 8'h01, "R1 reset state");
        write_en(2'b10);
        expect_out(1'b1, 8'h02, "R1 first TX enable fires at once");
    endtask

    task automatic t_delay_and_retrigger;
        do_reset();
        write_en(2'b01);
        pulse_rx_req();
        step(D - 1);
        expect_out(1'b0, 8'h01, "R2 one edge before delay");
        step(1);
        expect_out(1'b1, 8'h04, "R2 delayed RX set");
        do_reset();
        write_en(2'b01);
        pulse_rx_req();
        step(4);
        pulse_rx_req();
        step(D - 5);
        expect_out(1'b0, 8'h01, "R3 first request superseded");
        step(4);
        expect_out(1'b0, 8'h01, "R3 edge before restarted expiry");
        step(1);
        expect_out(1'b1, 8'h04, "R3 restarted expiry");
    endtask

    task automatic t_disabled_expiry;
        do_reset();
        pulse_tx_req();
        pulse_rx_req();
        step(D + 3);
        expect_out(1'b0, 8'h01, "R4 expiry with enables off");
    endtask

    task automatic t_tx_enable_age;
        do_reset();
        write_en(2'b10);
        expect_out(1'b1, 8'h02, "R5 immediate TX");
        pulse_id_rd();
        write_en(2'b00);
        write_en(2'b10);
        expect_out(1'b0, 8'h01, "R6 recent TX defers");
        step(D - 1);
        expect_out(1'b0, 8'h01, "R6 edge before deferred TX");
        step(1);
        expect_out(1'b1, 8'h02, "R6 deferred TX set");
        pulse_id_rd();
        step(2 * D + 5);
        write_en(2'b00);
        write_en(2'b10);
        expect_out(1'b1, 8'h02, "R5 immediate TX after long idle");
    endtask

    task automatic t_tx_disable;
        do_reset();
        write_en(2'b10);
        write_en(2'b00);
        expect_out(1'b0, 8'h01, "R7 disable clears TX pending");
        write_en(2'b10);
        step(3);
        write_en(2'b00);
        step(D + 2);
        expect_out(1'b0, 8'h01, "R7 disable stops TX timer");
    endtask

    task automatic t_rx_enable;
        do_reset();
        rx_avail = 1'b1;
        write_en(2'b01);
        step(D - 1);
        expect_out(1'b0, 8'h01, "R8 edge before RX expiry");
        step(1);
        expect_out(1'b1, 8'h04, "R8 RX scheduled by enable");
        rx_avail = 1'b0;
        write_en(2'b01);
        expect_out(1'b0, 8'h01, "R8 enable without data clears RX");
        rx_avail = 1'b1;
        write_en(2'b01);
        step(3);
        rx_avail = 1'b0;
        write_en(2'b01);
        step(D + 2);
        expect_out(1'b0, 8'h01, "R8 RX timer cancelled");
    endtask

    task automatic t_arrive;
        do_reset();
        pulse_arrive();
        expect_out(1'b0, 8'h01, "R11 arrival with RX disabled");
        write_en(2'b01);
        pulse_arrive();
        expect_out(1'b1, 8'h04, "R11 arrival raises at once");
    endtask

    task automatic t_priority;
        do_reset();
        write_en(2'b11);
        expect_out(1'b1, 8'h02, "R9 TX only");
        pulse_arrive();
        expect_out(1'b1, 8'h04, "R9 RX over TX");
        pulse_id_rd();
        expect_out(1'b1, 8'h04, "R10 read keeps RX and TX");
        pulse_rx_req();
        expect_out(1'b1, 8'h02, "R9 TX shown after RX clears");
        pulse_id_rd();
        expect_out(1'b0, 8'h01, "R10 read clears TX");
    endtask

    initial begin
        t_reset_state();
        t_delay_and_retrigger();
        t_disabled_expiry();
        t_tx_enable_age();
        t_tx_disable();
        t_rx_enable();
        t_arrive();
        t_priority();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule